// File: doc/BRIEF.md
# Hardware Return-Address Stack

This block stores return addresses for a small processor core. It has a dedicated set of sixteen 15-bit entries, kept apart from program and data memory. A call, a call through the working register, or an interrupt vector saves the current program counter. A return, a return with a literal, or a return from interrupt hands the saved value back. The core's page-latch register plays no part in either action. A 5-bit pointer always addresses the entry in use. Its all-ones value marks an empty stack, and software can read it at any time to see how much room is left.

A push advances the pointer and then writes the incoming PC into the entry the pointer now selects. A pop presents the selected entry as the return PC and then moves the pointer back. Running past either end always sets a sticky flag. A configuration input then chooses what happens next: either the block raises a one-cycle reset request for the core, or the stack simply keeps going as a ring, so that the seventeenth push lands on the first entry.

Software can load the pointer, and through it choose an entry. It reads and writes that entry as a pair of 8-bit views: one for the upper PC bits and one for the lower PC bits.

The control is split into two small state machines:
- **Pointer operation selector** (`ptr_op_e`). Each cycle it picks exactly one of four operations, listed here in falling priority: `OP_PUSH`, `OP_POP`, `OP_LOAD` (software pointer write) and `OP_HOLD`. Every operation returns to the selector in the next cycle.
- **Fault-reset machine** (`trap_state_e`). It has two states, `TRAP_IDLE` and `TRAP_FIRE`, and three transitions:
  - `TRAP_IDLE` to `TRAP_FIRE` on an overflow or underflow while reset mode is selected.
  - `TRAP_FIRE` to `TRAP_FIRE` on another such fault.
  - `TRAP_FIRE` to `TRAP_IDLE` in any other cycle.

Top module: `pc_return_stack`

## Requirements
- R1: After reset the pointer reads 0x1F (empty), both flags read 0, the reset request is low and every entry holds 0.
- R2: A push moves the pointer from 0x1F to 0x00, and from n to n+1 for n in 0x00..0x0E. It then stores `push_pc` in the entry the new pointer selects. A pop at a pointer n in 0x01..0x0F moves the pointer to n-1. `pop_pc` always shows the entry the current pointer selects, which is the value a pop returns.
- R3: `tos_hi` bits 6:0 carry bits 14:8 of the selected entry, and its bit 7 always reads 0. `tos_lo` carries bits 7:0. A write to the high view stores `sw_wdata[6:0]` into bits 14:8 and drops `sw_wdata[7]`. A write to the low view stores `sw_wdata` into bits 7:0.
- R4: A push at pointer 0x0F is an overflow. It sets `ovf_flag`, the pointer becomes 0x00, and entry 0 is overwritten, as in a circular buffer.
- R5: A pop at pointer 0x00, or at a pointer with bit 4 set, is an underflow. It sets `unf_flag`, and the pointer becomes 0x1F.
- R6: With `cfg_fault_reset` = 1, `rst_req` is high for exactly the cycle after each overflow or underflow. With `cfg_fault_reset` = 0, it never rises.
- R7: While pointer bit 4 is set, the selected entry reads as 0 if `cfg_fault_reset` = 1. If `cfg_fault_reset` = 0, it reads as the entry numbered by pointer bits 3:0, so the empty pointer 0x1F shows entry 0x0F. This holds for `tos_hi`, `tos_lo` and `pop_pc` alike.
- R8: A pointer load takes `sw_wdata[4:0]` in the next cycle, and the load selects which entry the views access. Pointer loads and view writes made in a cycle with a push or pop request are ignored.
- R9: A push and a pop requested in the same cycle perform only the push.
- R10: Each flag stays set until its clear input is pulsed. A clear in the same cycle as a new event leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fault_reset | input | 1 | 1: request core reset on overflow/underflow; 0: circular operation |
| push_req | input | 1 | Save `push_pc` (call or interrupt vector) |
| push_pc | input | 15 | PC value to save |
| pop_req | input | 1 | Return: consume the selected entry |
| pop_pc | output | 15 | Selected entry, the return address |
| sw_ptr_we | input | 1 | Software pointer load |
| sw_hi_we | input | 1 | Software write of the selected entry's upper bits |
| sw_lo_we | input | 1 | Software write of the selected entry's lower bits |
| sw_wdata | input | 8 | Software write data |
| clr_ovf | input | 1 | Clear the overflow flag |
| clr_unf | input | 1 | Clear the underflow flag |
| ptr | output | 5 | Current pointer |
| tos_hi | output | 8 | Upper view of the selected entry |
| tos_lo | output | 8 | Lower view of the selected entry |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |
| rst_req | output | 1 | One-cycle core reset request |

## Verification
The bench runs the same sequence under both configuration values and keeps a full arithmetic model of the stack.

It pushes seventeen times so the ring wraps. A design that wrapped to the wrong pointer, or did not overwrite entry 0, would return the wrong value on the next pop. It pops past the bottom twice, once from 0x00 and once from the empty state. A design that treated 0x1F as an ordinary index, or that raised a reset request in circular mode, would show a wrong pointer or a stray pulse.

It also sweeps a pointer load and both view writes across every entry. This catches a misplaced high-view field or a bit 7 that leaks into the stored value.

Finally it collides a push with a pop, a clear with a new event, and software writes with core activity. A design with the wrong priority would move the pointer the wrong way, or lose a flag.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_PUSH,
        OP_POP,
        OP_LOAD
    } ptr_op_e;

    typedef enum logic {
        TRAP_IDLE,
        TRAP_FIRE
    } trap_state_e;

endpackage

// File: rtl/rs_ptr_ctrl.sv
module rs_ptr_ctrl
    import rs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_fault_reset,
    input  logic                   push_req,
    input  logic                   pop_req,
    input  logic                   sw_ptr_we,
    input  logic [$clog2(DEPTH):0] sw_ptr_wdata,
    input  logic                   clr_ovf,
    input  logic                   clr_unf,
    output logic [$clog2(DEPTH):0] ptr,
    output logic                   push_we,
    output logic [$clog2(DEPTH)-1:0] push_idx,
    output logic                   ovf_flag,
    output logic                   unf_flag,
    output logic                   rst_req
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;
    localparam logic [PTR_W-1:0] EMPTY    = {PTR_W{1'b1}};
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    ptr_op_e          op;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             ovf_ev, unf_ev;
    logic             ovf_q, unf_q;
    trap_state_e      trap_q, trap_d;

    // Operation selection: push beats pop, core beats software.
    always_comb begin
        if (push_req)       op = OP_PUSH;
        else if (pop_req)   op = OP_POP;
        else if (sw_ptr_we) op = OP_LOAD;
        else                op = OP_HOLD;
    end

    // Next pointer and fault events.
    always_comb begin
        ptr_d  = ptr_q;
        ovf_ev = 1'b0;
        unf_ev = 1'b0;
        unique case (op)
            OP_PUSH: begin
                if (ptr_q[IDX_W]) begin
                    ptr_d = '0;
                end else if (ptr_q[IDX_W-1:0] == LAST_IDX) begin
                    ptr_d  = '0;
                    ovf_ev = 1'b1;
                end else begin
                    ptr_d = ptr_q + PTR_W'(1);
                end
            end
            OP_POP: begin
                if (ptr_q[IDX_W] || ptr_q == '0) begin
                    ptr_d  = EMPTY;
                    unf_ev = 1'b1;
                end else begin
                    ptr_d = ptr_q - PTR_W'(1);
                end
            end
            OP_LOAD: ptr_d = sw_ptr_wdata;
            OP_HOLD: ptr_d = ptr_q;
        endcase
    end

    // Fault-reset machine transitions.
    always_comb begin
        unique case (trap_q)
            TRAP_IDLE: trap_d = ((ovf_ev || unf_ev) && cfg_fault_reset) ? TRAP_FIRE : TRAP_IDLE;
            TRAP_FIRE: trap_d = ((ovf_ev || unf_ev) && cfg_fault_reset) ? TRAP_FIRE : TRAP_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= EMPTY;
            trap_q <= TRAP_IDLE;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            ptr_q  <= ptr_d;
            trap_q <= trap_d;
            if (ovf_ev)       ovf_q <= 1'b1;
            else if (clr_ovf) ovf_q <= 1'b0;
            if (unf_ev)       unf_q <= 1'b1;
            else if (clr_unf) unf_q <= 1'b0;
        end
    end

    // Outputs.
    always_comb begin
        unique case (trap_q)
            TRAP_IDLE: rst_req = 1'b0;
            TRAP_FIRE: rst_req = 1'b1;
        endcase
    end

    assign ptr      = ptr_q;
    assign ovf_flag = ovf_q;
    assign unf_flag = unf_q;
    assign push_we  = (op == OP_PUSH);
    assign push_idx = ptr_d[IDX_W-1:0];

    a_r4_overflow_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !ptr_q[IDX_W] && ptr_q[IDX_W-1:0] == LAST_IDX) |=> (ptr_q == '0 && ovf_q));

    a_r5_underflow_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && (ptr_q[IDX_W] || ptr_q == '0)) |=> (ptr_q == EMPTY && unf_q));

    a_r6_no_req_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fault_reset |=> !rst_req);

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_ovf) |=> ovf_q);

    a_r10_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_q && !clr_unf) |=> unf_q);

    a_r9_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && ptr_q == EMPTY) |=> (ptr_q == '0));

endmodule

// File: rtl/rs_entry_bank.sv
module rs_entry_bank #(
    parameter int DEPTH = 16,
    parameter int PC_W  = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_we,
    input  logic [$clog2(DEPTH)-1:0] push_idx,
    input  logic [PC_W-1:0]          push_data,
    input  logic                     sw_hi_we,
    input  logic                     sw_lo_we,
    input  logic [$clog2(DEPTH)-1:0] sw_idx,
    input  logic [7:0]               sw_wdata,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [PC_W-1:0]          rd_data
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int HI_W  = PC_W - 8;

    logic [PC_W-1:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [PC_W-1:0] q;
        logic            sel_push, sel_sw;
        assign sel_push = push_we && (push_idx == IDX_W'(g));
        assign sel_sw   = sw_idx == IDX_W'(g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (sel_push) begin
                q <= push_data;
            end else begin
                if (sw_hi_we && sel_sw) q[PC_W-1:8] <= sw_wdata[HI_W-1:0];
                if (sw_lo_we && sel_sw) q[7:0]      <= sw_wdata;
            end
        end
        assign ent[g] = q;
    end

    assign rd_data = ent[rd_idx];

    a_r2_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
        push_we |=> (ent[$past(push_idx)] == $past(push_data)));

endmodule

// File: rtl/rs_tos_view.sv
module rs_tos_view #(
    parameter int DEPTH = 16,
    parameter int PC_W  = 15
) (
    input  logic                   cfg_fault_reset,
    input  logic [$clog2(DEPTH):0] ptr,
    input  logic [PC_W-1:0]        entry,
    output logic [PC_W-1:0]        tos_pc,
    output logic [7:0]             tos_hi,
    output logic [7:0]             tos_lo
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int HI_W  = PC_W - 8;

    logic outside;
    assign outside = ptr[IDX_W];

    always_comb begin
        if (outside && cfg_fault_reset) tos_pc = '0;
        else                            tos_pc = entry;
    end

    assign tos_hi = {{(8 - HI_W){1'b0}}, tos_pc[PC_W-1:8]};
    assign tos_lo = tos_pc[7:0];

    always_comb begin
        a_r3_hi_msb_zero: assert (tos_hi[7] == 1'b0);
    end

endmodule

// File: rtl/pc_return_stack.sv
module pc_return_stack #(
    parameter int DEPTH = 16,
    parameter int PC_W  = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_fault_reset,
    input  logic                   push_req,
    input  logic [PC_W-1:0]        push_pc,
    input  logic                   pop_req,
    output logic [PC_W-1:0]        pop_pc,
    input  logic                   sw_ptr_we,
    input  logic                   sw_hi_we,
    input  logic                   sw_lo_we,
    input  logic [7:0]             sw_wdata,
    input  logic                   clr_ovf,
    input  logic                   clr_unf,
    output logic [$clog2(DEPTH):0] ptr,
    output logic [7:0]             tos_hi,
    output logic [7:0]             tos_lo,
    output logic                   ovf_flag,
    output logic                   unf_flag,
    output logic                   rst_req
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    logic             core_busy;
    logic             push_we;
    logic [IDX_W-1:0] push_idx;
    logic [PC_W-1:0]  entry;

    assign core_busy = push_req || pop_req;

    rs_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_fault_reset (cfg_fault_reset),
        .push_req        (push_req),
        .pop_req         (pop_req),
        .sw_ptr_we       (sw_ptr_we),
        .sw_ptr_wdata    (sw_wdata[PTR_W-1:0]),
        .clr_ovf         (clr_ovf),
        .clr_unf         (clr_unf),
        .ptr             (ptr),
        .push_we         (push_we),
        .push_idx        (push_idx),
        .ovf_flag        (ovf_flag),
        .unf_flag        (unf_flag),
        .rst_req         (rst_req)
    );

    rs_entry_bank #(.DEPTH(DEPTH), .PC_W(PC_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_we   (push_we),
        .push_idx  (push_idx),
        .push_data (push_pc),
        .sw_hi_we  (sw_hi_we && !core_busy),
        .sw_lo_we  (sw_lo_we && !core_busy),
        .sw_idx    (ptr[IDX_W-1:0]),
        .sw_wdata  (sw_wdata),
        .rd_idx    (ptr[IDX_W-1:0]),
        .rd_data   (entry)
    );

    rs_tos_view #(.DEPTH(DEPTH), .PC_W(PC_W)) u_view (
        .cfg_fault_reset (cfg_fault_reset),
        .ptr             (ptr),
        .entry           (entry),
        .tos_pc          (pop_pc),
        .tos_hi          (tos_hi),
        .tos_lo          (tos_lo)
    );

    a_r8_sw_load_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ptr_we && push_req && ptr == 5'h1F) |=> (ptr == 5'h00));

endmodule

// File: tb/pc_return_stack_bench.sv
module pc_return_stack_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg = 1'b0;
    logic        push_req = 0, pop_req = 0, sw_ptr_we = 0, sw_hi_we = 0, sw_lo_we = 0;
    logic        clr_ovf = 0, clr_unf = 0;
    logic [14:0] push_pc = '0;
    logic [7:0]  sw_wdata = '0;
    logic [14:0] pop_pc;
    logic [4:0]  ptr;
    logic [7:0]  tos_hi, tos_lo;
    logic        ovf_flag, unf_flag, rst_req;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench model of the stack, built from the requirements.
    logic [14:0] mm [16];
    logic [4:0]  mp;
    logic        mo, mu, mr;

    always #5 clk = ~clk;

    pc_return_stack u_pc_return_stack (
        .clk(clk), .rst_n(rst_n), .cfg_fault_reset(cfg),
        .push_req(push_req), .push_pc(push_pc), .pop_req(pop_req), .pop_pc(pop_pc),
        .sw_ptr_we(sw_ptr_we), .sw_hi_we(sw_hi_we), .sw_lo_we(sw_lo_we), .sw_wdata(sw_wdata),
        .clr_ovf(clr_ovf), .clr_unf(clr_unf), .ptr(ptr), .tos_hi(tos_hi), .tos_lo(tos_lo),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag), .rst_req(rst_req)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [14:0] e;
        e = (cfg && mp[4]) ? 15'h0 : mm[mp[3:0]];
        chk(tag, "ptr", int'(ptr), int'(mp));
        chk(tag, "tos_hi", int'(tos_hi), int'({1'b0, e[14:8]}));
        chk(tag, "tos_lo", int'(tos_lo), int'(e[7:0]));
        chk(tag, "pop_pc", int'(pop_pc), int'(e));
        chk(tag, "ovf_flag", int'(ovf_flag), int'(mo));
        chk(tag, "unf_flag", int'(unf_flag), int'(mu));
        chk(tag, "rst_req", int'(rst_req), int'(mr));
    endtask

    // One clock cycle of stimulus, model update, then a full check.
    task automatic act(input string tag, input logic pu, input logic po, input logic [14:0] pv,
                       input logic lp, input logic wh, input logic wl, input logic [7:0] wd,
                       input logic co, input logic cu);
        logic oev, uev;
        logic [4:0] np;
        push_req = pu; pop_req = po; push_pc = pv; sw_ptr_we = lp;
        sw_hi_we = wh; sw_lo_we = wl; sw_wdata = wd; clr_ovf = co; clr_unf = cu;
        @(negedge clk);
        push_req = 0; pop_req = 0; sw_ptr_we = 0; sw_hi_we = 0; sw_lo_we = 0;
        clr_ovf = 0; clr_unf = 0;
        oev = 0; uev = 0; np = mp;
        if (pu) begin
            if (mp[4]) np = 5'h00;
            else if (mp == 5'h0F) begin np = 5'h00; oev = 1; end
            else np = mp + 5'd1;
            mm[np[3:0]] = pv;
        end else if (po) begin
            if (mp[4] || mp == 5'h00) begin np = 5'h1F; uev = 1; end
            else np = mp - 5'd1;
        end else begin
            if (wh) mm[mp[3:0]][14:8] = wd[6:0];
            if (wl) mm[mp[3:0]][7:0]  = wd;
            if (lp) np = wd[4:0];
        end
        mp = np;
        if (oev) mo = 1; else if (co) mo = 0;
        if (uev) mu = 1; else if (cu) mu = 0;
        mr = (oev || uev) && cfg;
        check_all(tag);
    endtask

    task automatic idle(input string tag);
        act(tag, 0, 0, 15'h0, 0, 0, 0, 8'h0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 16; i++) mm[i] = '0;
        mp = 5'h1F; mo = 0; mu = 0; mr = 0;
        @(negedge clk);
        check_all("R1");
    endtask

    function automatic logic [14:0] val(input int k, input logic c);
        return 15'((k * 4909 + int'(c) * 1111 + 3) & 32'h7FFF);
    endfunction

    initial begin
        for (int c = 0; c < 2; c++) begin
            cfg = c[0];
            do_reset();
            for (int k = 0; k < 17; k++)
                act((k == 16) ? "R4" : "R2", 1, 0, val(k, cfg), 0, 0, 0, 8'h0, 0, 0);
            idle("R6");
            idle("R10");
            act("R5", 0, 1, 15'h0, 0, 0, 0, 8'h0, 0, 0);
            check_all("R7");
            act("R5", 0, 1, 15'h0, 0, 0, 0, 8'h0, 0, 0);
            act("R10", 0, 1, 15'h0, 0, 0, 0, 8'h0, 0, 1);
            act("R10", 0, 0, 15'h0, 0, 0, 0, 8'h0, 1, 1);
            for (int p = 0; p < 16; p++) begin
                act("R8", 0, 0, 15'h0, 1, 0, 0, 8'(p), 0, 0);
                act("R3", 0, 0, 15'h0, 0, 1, 0, 8'(8'h80 | (p * 5)), 0, 0);
                act("R3", 0, 0, 15'h0, 0, 0, 1, 8'(p * 11 + 1), 0, 0);
            end
            act("R7", 0, 0, 15'h0, 1, 0, 0, 8'h1F, 0, 0);
            act("R7", 0, 0, 15'h0, 1, 0, 0, 8'h14, 0, 0);
            act("R8", 0, 0, 15'h0, 1, 0, 0, 8'h0F, 0, 0);
            for (int k = 0; k < 16; k++)
                act("R2", 0, 1, 15'h0, 0, 0, 0, 8'h0, 0, 0);
            act("R8", 0, 0, 15'h0, 1, 0, 0, 8'h03, 0, 0);
            act("R9", 1, 1, 15'h5A5A, 0, 0, 0, 8'h0, 0, 0);
            act("R8", 1, 0, 15'h1234, 1, 0, 0, 8'h0A, 0, 0);
            act("R8", 0, 1, 15'h0, 0, 1, 1, 8'h77, 0, 0);
            idle("R8");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule